// File: doc/BRIEF.md
# Configurable External Interrupt Edge Detector

This block turns two groups of external input pins into two interrupt request lines, one per group. Group A has four pins and group F has three. Every pin first passes through a two-flop synchroniser. A per-source detector then looks for edges, or for a low level, on any pin of its group. A detected event sets that source's pending flag, which drives the request output. The interrupt controller drops the flag with a one-cycle clear pulse.

One 2-bit sensitivity register sets the trigger condition for both groups together. It can be written only while the CPU interrupt mask input is high, meaning interrupts are disabled. A write made while the mask is low is dropped. The current sensitivity value is visible on a read-back port.

Each source runs a two-state machine:
- `SRC_IDLE`: no request.
- `SRC_PEND`: request asserted.

The transitions are:
- T_SET: `SRC_IDLE` to `SRC_PEND` when the trigger condition is true.
- T_HOLD: stay in `SRC_PEND` while no clear arrives, or while the trigger is still true during a clear.
- T_CLR: `SRC_PEND` to `SRC_IDLE` when a clear arrives and the trigger is false.
- T_WAIT: stay in `SRC_IDLE` while there is no trigger.

The synchroniser flops reset to the high (inactive) pin level.

Top module: `eid_top`

## Requirements
- R1: After reset, `sens_rd` reads 2'b00 and both `irq_a` and `irq_f` are 0.
- R2: A write with `cfg_we`=1 while `cpu_imask`=1 loads `cfg_wdata` into the sensitivity register, visible on `sens_rd` one cycle later.
- R3: A write while `cpu_imask`=0 is ignored and `sens_rd` keeps its value.
- R4: Sensitivity 2'b01 (rising only): a 0-to-1 change on any pin of a group sets that group's request; a 1-to-0 change does not.
- R5: Sensitivity 2'b10 (falling only): a 1-to-0 change on any pin sets the request; a 0-to-1 change does not.
- R6: Sensitivity 2'b11 (both edges): a change in either direction on any pin sets the request.
- R7: Sensitivity 2'b00 (falling edge and low level): a pin going low sets the request. A clear while any pin of the group is still low leaves the request set. A clear after all pins are high again drops it.
- R8: In the edge modes a request stays asserted until a clear pulse on that group's clear input, and it drops in the cycle after the clear.
- R9: The two groups are independent: pin events and clears of one group never change the other group's request.
- R10: A pin change applied before clock edge k appears on the request output after edge k+2 and not earlier (two synchroniser flops plus the pending register).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_a | input | 4 | Asynchronous pins of group A |
| pins_f | input | 3 | Asynchronous pins of group F |
| cpu_imask | input | 1 | CPU interrupt mask; 1 = interrupts disabled, config writable |
| cfg_we | input | 1 | Sensitivity register write strobe |
| cfg_wdata | input | 2 | Sensitivity value: 00 fall+low, 01 rise, 10 fall, 11 both |
| clr_a | input | 1 | Clear pulse for group A request |
| clr_f | input | 1 | Clear pulse for group F request |
| irq_a | output | 1 | Group A interrupt request |
| irq_f | output | 1 | Group F interrupt request |
| sens_rd | output | 2 | Current sensitivity register value |

## Verification
The checker watches the configuration lock on every cycle: a masked write must land and an unmasked write must never move the register. It also checks on every cycle that a request held without a clear never drops, on either group. The mode decode, the three-edge latency, the level re-assertion after a clear in mode 00, and group independence depend on pin histories. Only the bench's scenarios show these, through the vector table and the directed sequences.

// File: rtl/eid_pkg.sv
package eid_pkg;

    typedef enum logic [1:0] {
        SENS_FALL_LOW = 2'b00,
        SENS_RISE     = 2'b01,
        SENS_FALL     = 2'b10,
        SENS_BOTH     = 2'b11
    } sens_e;

    typedef enum logic {
        SRC_IDLE = 1'b0,
        SRC_PEND = 1'b1
    } src_st_e;

endpackage

// File: rtl/eid_sync.sv
module eid_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '1;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[LAST];
endmodule

// File: rtl/eid_cfg.sv
module eid_cfg
    import eid_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_imask,
    input  logic       we,
    input  logic [1:0] wdata,
    output sens_e      sens
);
    logic accept;

    assign accept = we && cpu_imask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sens <= SENS_FALL_LOW;
        else if (accept) sens <= sens_e'(wdata);
    end
endmodule

// File: rtl/eid_source.sv
module eid_source
    import eid_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_s,
    input  sens_e        sens,
    input  logic         clr,
    output logic         irq
);
    logic [W-1:0] prev_q;
    logic [W-1:0] fall_v;
    logic [W-1:0] rise_v;
    logic         low_any;
    logic         trig;
    src_st_e      st_q;
    src_st_e      st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= pins_s;
    end

    assign fall_v  = prev_q & ~pins_s;
    assign rise_v  = ~prev_q & pins_s;
    assign low_any = |(~pins_s);

    always_comb begin
        unique case (sens)
            SENS_FALL_LOW: trig = (|fall_v) || low_any;
            SENS_RISE:     trig = |rise_v;
            SENS_FALL:     trig = |fall_v;
            SENS_BOTH:     trig = |(rise_v | fall_v);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SRC_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            SRC_IDLE: st_d = trig ? SRC_PEND : SRC_IDLE;
            SRC_PEND: st_d = (clr && !trig) ? SRC_IDLE : SRC_PEND;
        endcase
    end

    always_comb begin
        irq = (st_q == SRC_PEND);
    end
endmodule

// File: rtl/eid_top.sv
module eid_top
    import eid_pkg::*;
#(
    parameter int NA     = 4,
    parameter int NF     = 3,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NA-1:0] pins_a,
    input  logic [NF-1:0] pins_f,
    input  logic          cpu_imask,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_wdata,
    input  logic          clr_a,
    input  logic          clr_f,
    output logic          irq_a,
    output logic          irq_f,
    output logic [1:0]    sens_rd
);
    sens_e         sens;
    logic [NA-1:0] a_s;
    logic [NF-1:0] f_s;

    eid_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .cpu_imask(cpu_imask),
        .we(cfg_we), .wdata(cfg_wdata), .sens(sens)
    );

    eid_sync #(.W(NA), .STAGES(STAGES)) u_sync_a (
        .clk(clk), .rst_n(rst_n), .d(pins_a), .q(a_s)
    );
    eid_sync #(.W(NF), .STAGES(STAGES)) u_sync_f (
        .clk(clk), .rst_n(rst_n), .d(pins_f), .q(f_s)
    );

    eid_source #(.W(NA)) u_src_a (
        .clk(clk), .rst_n(rst_n), .pins_s(a_s), .sens(sens),
        .clr(clr_a), .irq(irq_a)
    );
    eid_source #(.W(NF)) u_src_f (
        .clk(clk), .rst_n(rst_n), .pins_s(f_s), .sens(sens),
        .clr(clr_f), .irq(irq_f)
    );

    assign sens_rd = sens;
endmodule

// File: rtl/eid_chk.sv
module eid_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_imask,
    input logic       cfg_we,
    input logic [1:0] cfg_wdata,
    input logic [1:0] sens_rd,
    input logic       irq_a,
    input logic       clr_a,
    input logic       irq_f,
    input logic       clr_f
);
    AST_CFG_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_imask && cfg_we) |=> (sens_rd == $past(cfg_wdata)));          // R2
    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_imask) |=> $stable(sens_rd));                                 // R3
    AST_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_a && !clr_a) |=> irq_a);                                       // R8
    AST_HOLD_F: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_f && !clr_f) |=> irq_f);                                       // R8
endmodule

bind eid_top eid_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_imask(cpu_imask), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .sens_rd(sens_rd), .irq_a(irq_a), .clr_a(clr_a),
    .irq_f(irq_f), .clr_f(clr_f)
);

// File: tb/eid_top_bench.sv
`timescale 1ns/1ps
module eid_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pins_a = 4'hF;
    logic [2:0] pins_f = 3'h7;
    logic       cpu_imask = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_wdata = 2'b00;
    logic       clr_a = 1'b0;
    logic       clr_f = 1'b0;
    logic       irq_a, irq_f;
    logic [1:0] sens_rd;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    eid_top u_eid_top (
        .clk(clk), .rst_n(rst_n), .pins_a(pins_a), .pins_f(pins_f),
        .cpu_imask(cpu_imask), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .clr_a(clr_a), .clr_f(clr_f), .irq_a(irq_a), .irq_f(irq_f),
        .sens_rd(sens_rd)
    );

    // {mode, pins before, pins after, expected irq_a}
    localparam int NV = 10;
    localparam logic [10:0] VEC [NV] = '{
        {2'b01, 4'hF, 4'hE, 1'b0},   // R4 falling ignored
        {2'b01, 4'hE, 4'hF, 1'b1},   // R4 rising
        {2'b10, 4'hF, 4'hE, 1'b1},   // R5 falling
        {2'b10, 4'hE, 4'hF, 1'b0},   // R5 rising ignored
        {2'b11, 4'hF, 4'h7, 1'b1},   // R6 falling
        {2'b11, 4'h7, 4'hF, 1'b1},   // R6 rising
        {2'b00, 4'hF, 4'hB, 1'b1},   // R7 low
        {2'b01, 4'hF, 4'hF, 1'b0},   // R4 no change
        {2'b10, 4'h5, 4'h4, 1'b1},   // R5 pin0 falls
        {2'b01, 4'hA, 4'hB, 1'b1}    // R4 pin0 rises
    };

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_cfg(input logic mask, input logic [1:0] v);
        cpu_imask = mask; cfg_we = 1'b1; cfg_wdata = v;
        tick(1);
        cfg_we = 1'b0; cpu_imask = 1'b0;
    endtask

    task automatic pulse_clr_a();
        clr_a = 1'b1; tick(1); clr_a = 1'b0;
    endtask

    task automatic pulse_clr_f();
        clr_f = 1'b1; tick(1); clr_f = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check(sens_rd == 2'b00, 1'b1, "R1 sens reset");
        check(irq_a, 1'b0, "R1 irq_a reset");
        check(irq_f, 1'b0, "R1 irq_f reset");

        // R3: write while interrupts enabled
        write_cfg(1'b0, 2'b11);
        tick(1);
        check(sens_rd == 2'b00, 1'b1, "R3 write ignored");
        // R2: write while masked
        write_cfg(1'b1, 2'b10);
        check(sens_rd == 2'b10, 1'b1, "R2 write taken");
        write_cfg(1'b0, 2'b01);
        check(sens_rd == 2'b10, 1'b1, "R3 write ignored again");

        for (int i = 0; i < NV; i++) begin
            pins_a = VEC[i][8:5];
            tick(4);
            write_cfg(1'b1, VEC[i][10:9]);
            tick(4);
            pulse_clr_a();
            tick(1);
            check(irq_a, 1'b0, "R8 table baseline cleared");
            pins_a = VEC[i][4:1];
            tick(3);
            check(irq_a, VEC[i][0], $sformatf("R4/R5/R6/R7 table entry %0d", i));
        end
        pins_a = 4'hF;
        tick(4);
        pulse_clr_a();

        // R10 latency and R9 group F pin, mode falling-only
        write_cfg(1'b1, 2'b10);
        pulse_clr_f();
        pins_f = 3'h3;           // pin2 falls
        tick(2);
        check(irq_f, 1'b0, "R10 not before third edge");
        tick(1);
        check(irq_f, 1'b1, "R10 request after third edge");
        check(irq_a, 1'b0, "R9 group A untouched by F event");
        // R8 hold then clear
        tick(5);
        check(irq_f, 1'b1, "R8 request held");
        pulse_clr_a();
        check(irq_f, 1'b1, "R9 clr_a leaves irq_f");
        pulse_clr_f();
        check(irq_f, 1'b0, "R8 cleared after pulse");
        pins_f = 3'h7;
        tick(4);

        // R7 level behaviour on group A
        write_cfg(1'b1, 2'b00);
        pins_a = 4'hD;
        tick(3);
        check(irq_a, 1'b1, "R7 low sets request");
        pulse_clr_a();
        tick(1);
        check(irq_a, 1'b1, "R7 clear while low keeps request");
        pins_a = 4'hF;
        tick(4);
        check(irq_a, 1'b1, "R7 request stays until clear");
        pulse_clr_a();
        check(irq_a, 1'b0, "R7 clear after high drops request");
        check(irq_f, 1'b0, "R9 group F unaffected");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule